// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A command strobe loads a starting column, a burst length code and an ordering choice. On each later effective clock edge the block steps to the next column of the burst. It also raises a flag on the final beat of a fixed-length burst. A command or data sequencer sits next to it and uses the column output to index the open row.

There are two orderings for fixed lengths of 1, 2, 4 and 8. Linear ordering counts upward inside the aligned block of burst-length columns and wraps within it. Interleaved ordering XORs the beat index into the low column bits. A page-length burst steps through the whole row and wraps from the top column to zero. It keeps going until a stop strobe arrives, and it always uses linear ordering. A stop strobe can end any burst early. The clock-enable input follows SDRAM rules: when it was low at one edge, the next edge is dead, and the block holds everything and ignores its strobes at that edge.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, col_valid and last_beat are low.
- R2: After an effective edge with cmd_start high, col_valid is high and col_addr equals the start_col sampled at that edge (beat 0).
- R3: Codes 0, 1, 2 and 3 on bl_code select fixed lengths 1, 2, 4 and 8. With xor_order low, beat i shows start_col with its low log2(length) bits replaced by (start_col + i) mod length. All higher bits stay equal to start_col.
- R4: With xor_order high and a fixed length, beat i shows start_col with its low log2(length) bits XORed with i. Higher bits are unchanged.
- R5: Code 7 selects a page burst. The column rises by one on each effective edge and wraps from 2^COL_W-1 to 0. The burst never ends by itself, and xor_order has no effect.
- R6: last_beat is high exactly on the final beat (beat length-1) of a fixed burst and never during a page burst. After that beat's effective edge, with no new start, col_valid goes low.
- R7: An effective edge with cmd_stop high and cmd_start low ends an active burst, so col_valid is low after it.
- R8: cmd_start at an effective edge during an active burst restarts at the new start_col with the new settings. cmd_start wins over cmd_stop at the same edge.
- R9: When cke was low at an edge, the following edge is not effective. col_addr, col_valid and last_beat hold, and cmd_start and cmd_stop at that edge are ignored.
- R10: The unused codes 4, 5 and 6 on bl_code act as length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low makes the next edge non-effective |
| cmd_start | input | 1 | Begin a burst with the current settings |
| cmd_stop | input | 1 | Terminate the active burst |
| start_col | input | COL_W | Starting column of the burst |
| bl_code | input | 3 | Burst length code (0..3 fixed, 7 page, others length 1) |
| xor_order | input | 1 | 1 selects interleaved ordering for fixed lengths |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Current beat is the last one of a fixed burst |

## Verification
The sweep runs every start column in a low window and in a window just below the top of the page, across all fixed lengths and both orderings. Linear wrap that carried into the upper bits shows up there as a wrong column, and so does an XOR applied to too many bits. Page bursts that cross the top column check the wrap to zero. A design that stopped a page burst by itself, or raised the last flag during one, would also fail there. Further tests cover a dead edge after cke is low, with a stop strobe on that dead edge, a restart in mid-burst, and a start and stop on the same edge. A design that advanced on the dead edge, honoured the masked stop, or let stop beat start would show a shifted or missing beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [2:0] {
        BLC_1    = 3'd0,
        BLC_2    = 3'd1,
        BLC_4    = 3'd2,
        BLC_8    = 3'd3,
        BLC_PAGE = 3'd7
    } bl_code_e;

    typedef struct packed {
        logic       page;
        logic       xor_order;
        logic [1:0] len_log2;
    } burst_cfg_t;

    localparam int MAX_FIXED_LEN = 8;

    function automatic logic [7:0] len_mask(input logic [1:0] len_log2);
        return (8'd1 << len_log2) - 8'd1;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_col_pkg::*;
(
    input  logic [2:0]  code,
    input  logic        xor_req,
    output burst_cfg_t  cfg
);
    always_comb begin
        cfg = '0;
        case (code)
            BLC_1, BLC_2, BLC_4, BLC_8: begin
                cfg.page     = 1'b0;
                cfg.len_log2 = code[1:0];
            end
            BLC_PAGE: begin
                cfg.page     = 1'b1;
                cfg.len_log2 = 2'd3;
            end
            default: begin
                cfg.page     = 1'b0;
                cfg.len_log2 = 2'd0;
            end
        endcase
        cfg.xor_order = xor_req & ~cfg.page;
    end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             start,
    input  logic             stop,
    input  burst_cfg_t       cfg_in,
    input  logic [COL_W-1:0] col_in,
    output logic             edge_ok,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] base,
    output burst_cfg_t       cfg,
    output logic             at_end
);
    logic [COL_W-1:0] final_beat;

    assign final_beat = COL_W'(len_mask(cfg.len_log2));
    assign at_end     = ~cfg.page & (beat == final_beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_ok <= 1'b1;
            active  <= 1'b0;
            beat    <= '0;
            base    <= '0;
            cfg     <= '0;
        end else begin
            edge_ok <= cke;
            if (edge_ok) begin
                if (start) begin
                    active <= 1'b1;
                    beat   <= '0;
                    base   <= col_in;
                    cfg    <= cfg_in;
                end else if (active) begin
                    if (stop || at_end) begin
                        active <= 1'b0;
                    end else begin
                        beat <= beat + COL_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;

    assign mask = cfg.page ? {COL_W{1'b1}} : COL_W'(len_mask(cfg.len_log2));
    assign sum  = base + beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = mask[b] ? (cfg.xor_order ? (base[b] ^ beat[b]) : sum[b])
                                : base[b];
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             xor_order,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             last_beat
);
    localparam int MIN_COL_W = $clog2(MAX_FIXED_LEN);

    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_cur;
    logic             edge_ok;
    logic             active;
    logic             at_end;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;

    initial begin
        if (COL_W < MIN_COL_W) $error("COL_W too small for an 8-beat burst");
    end

    burst_cfg_decode u_dec (
        .code    (bl_code),
        .xor_req (xor_order),
        .cfg     (cfg_new)
    );

    burst_beat_seq #(.COL_W(COL_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cke     (cke),
        .start   (cmd_start),
        .stop    (cmd_stop),
        .cfg_in  (cfg_new),
        .col_in  (start_col),
        .edge_ok (edge_ok),
        .active  (active),
        .beat    (beat),
        .base    (base),
        .cfg     (cfg_cur),
        .at_end  (at_end)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base (base),
        .beat (beat),
        .cfg  (cfg_cur),
        .mask (mask),
        .col  (col_addr)
    );

    assign col_valid = active;
    assign last_beat = active & at_end;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cke,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             last_beat,
    input logic             edge_ok,
    input logic             page,
    input logic [COL_W-1:0] mask
);
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        edge_ok && cmd_start |=> col_valid && col_addr == $past(start_col));

    assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
        last_beat |-> col_valid && !page);

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
        last_beat && edge_ok && !cmd_start |=> !col_valid);

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (rst)
        col_valid && edge_ok && cmd_stop && !cmd_start |=> !col_valid);

    assert_dead_edge_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !edge_ok |=> $stable(col_addr) && $stable(col_valid) && $stable(last_beat));

    assert_page_steps_R5: assert property (@(posedge clk) disable iff (rst)
        col_valid && page && edge_ok && !cmd_start && !cmd_stop
        |=> col_valid && col_addr == $past(col_addr) + COL_W'(1));

    assert_upper_bits_held_R3: assert property (@(posedge clk) disable iff (rst)
        col_valid && !page && edge_ok && !cmd_start && !cmd_stop
        |=> !col_valid || ((col_addr & ~mask) == ($past(col_addr) & ~mask)));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .start_col (start_col),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .last_beat (last_beat),
    .edge_ok   (edge_ok),
    .page      (cfg_cur.page),
    .mask      (mask)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    localparam int COL_W = 10;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cke = 1'b1;
    logic             cmd_start = 1'b0;
    logic             cmd_stop = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       bl_code = '0;
    logic             xor_order = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             last_beat;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .start_col(start_col), .bl_code(bl_code), .xor_order(xor_order),
        .col_addr(col_addr), .col_valid(col_valid), .last_beat(last_beat)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int blen(input int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return PAGE;
        return 1;
    endfunction

    function automatic int exp_col(input int s, input int i, input int code, input bit x);
        int len, blk;
        len = blen(code);
        blk = (s / len) * len;
        if (code == 7) return (s + i) % PAGE;
        if (x) return blk + ((s % len) ^ i);
        return blk + ((s + i) % len);
    endfunction

    task automatic launch(input int s, input int code, input bit x);
        cmd_start = 1'b1; start_col = COL_W'(s); bl_code = 3'(code); xor_order = x;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic check_beat(input string req, input int s, input int i,
                              input int code, input bit x);
        int len;
        len = blen(code);
        check(req, int'(col_valid), 1);
        check(req, int'(col_addr), exp_col(s, i, code, x));
        check({req, "/R6"}, int'(last_beat), (code != 7 && i == len - 1) ? 1 : 0);
    endtask

    task automatic full_burst(input int s, input int code, input bit x);
        int len;
        len = blen(code);
        launch(s, code, x);
        for (int i = 0; i < len; i++) begin
            check_beat(x ? "R4" : (code > 3 ? "R10" : "R3"), s, i, code, x);
            @(negedge clk);
        end
        check("R6 end", int'(col_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(col_valid), 0);
        check("R1", int'(last_beat), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(col_valid), 0);
        check("R1", int'(last_beat), 0);

        // R2 R3 R4 sweep: low window and top window, all fixed lengths, both orders
        for (int w = 0; w < 2; w++)
            for (int s0 = 0; s0 < 16; s0++)
                for (int code = 0; code < 4; code++)
                    for (int x = 0; x < 2; x++)
                        full_burst(w ? PAGE - 16 + s0 : s0, code, x[0]);

        // R10: reserved codes behave as length 1
        for (int code = 4; code < 7; code++) full_burst(37, code, 1'b0);

        // R5: page burst crossing the top, xor_order ignored, then stop (R7)
        for (int x = 0; x < 2; x++) begin
            launch(PAGE - 5, 7, x[0]);
            for (int i = 0; i < 12; i++) begin
                check_beat("R5", PAGE - 5, i, 7, 1'b0);
                if (i == 11) cmd_stop = 1'b1;
                @(negedge clk);
            end
            cmd_stop = 1'b0;
            check("R7 page stop", int'(col_valid), 0);
        end

        // R7: stop in the middle of an 8-beat burst
        launch(100, 3, 1'b0);
        check_beat("R7", 100, 0, 3, 1'b0);
        @(negedge clk);
        check_beat("R7", 100, 1, 3, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        check("R7", int'(col_valid), 0);

        // R8: restart mid-burst, start beats stop at the same edge
        launch(200, 3, 1'b0);
        @(negedge clk);
        check_beat("R8", 200, 1, 3, 1'b0);
        cmd_stop = 1'b1;
        launch(301, 2, 1'b1);
        cmd_stop = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check_beat("R8", 301, i, 2, 1'b1);
            @(negedge clk);
        end
        check("R8 end", int'(col_valid), 0);

        // R9: one cycle of cke low makes the following edge dead; stop there ignored
        launch(3, 3, 1'b0);
        @(negedge clk);
        check_beat("R9", 3, 1, 3, 1'b0);
        cke = 1'b0;
        @(negedge clk);
        check_beat("R9", 3, 2, 3, 1'b0);
        cke = 1'b1;
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        check_beat("R9 hold", 3, 2, 3, 1'b0);
        for (int i = 3; i < 8; i++) begin
            @(negedge clk);
            check_beat("R9", 3, i, 3, 1'b0);
        end
        @(negedge clk);
        check("R9 end", int'(col_valid), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_vec++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule